// File: doc/BRIEF.md
# Two-Strike Interrupt Watchdog

This block is a watchdog made from a down-counting timer that software configures through a small register port. The counter moves only on cycles where a 1 MHz tick enable is high. When it runs out, it raises an interrupt and either reloads (periodic mode) or stops (one-shot mode). Letting the timer run out once is only a warning. If it runs out a second time while the first interrupt has still not been acknowledged, the block sends a fixed-length system reset request, provided the watchdog function is armed. Because of this, software programs half of the timeout it wants.

Software keeps the system alive by rewriting the period register with the run bit set, which restarts the count, and by acknowledging the pending interrupt. A sticky cause flag records that the watchdog requested a reset. This flag is held on its own power-on reset, so it survives the reset that the block's own pulse causes. The register port is plain control: a write strobe with address and data, and a read data bus decoded from the address with no wait state. It carries no stream, so the port has no valid/ready handshake and no back-pressure.

Top module: `wdt_two_strike`

## Requirements
- R1: After reset, `irq_o` and `sys_rst_o` are low, the timer is stopped, and every register reads zero.
- R2: A write to address 0 with bit 31 set loads the count from bits 29:0 and starts the timer. The counter decrements only on cycles with `tick_i` high. The timer expires on the tick that finds the count at 1 or 0, so a period of N (N≥1) expires on the N-th tick.
- R3: Bit 30 of address 0 selects the reload behaviour on expiry. When it is set, the count reloads to the programmed value. When it is clear, the count stays at 0 and the run bit (bit 31 read back at address 0) clears.
- R4: An expiry sets the pending interrupt, which drives `irq_o` and reads back as bit 30 of address 1. Writing a 1 to bit 30 of address 1 clears it.
- R5: When the timer expires while the interrupt is still pending and the watchdog is armed, `sys_rst_o` goes high on the next cycle and stays high for `RST_LEN` cycles. Armed means address 2 has bit 5 set (enable), bit 4 clear (timer select 0) and bit 2 set (reset enable).
- R6: When address 2 is not armed, a second expiry raises no reset request, and the interrupt stays pending.
- R7: Rewriting address 0 with bit 31 set restarts the count from the new value. If that write lands in the same cycle as an expiring tick, the write wins and no expiry occurs.
- R8: If an acknowledge write and an expiry land in the same cycle, the interrupt ends up pending and no reset request is raised.
- R9: A reset request sets the cause flag, read as bit 12 of address 2. The flag is unaffected by `rst_n`. It is cleared only by `por_n` or by writing a 1 to bit 12 of address 2.
- R10: Writing zero to address 2 and to address 0 stops the watchdog. Further ticks raise no interrupt and no reset request.
- R11: Address 3 reads the current count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| por_n | input | 1 | Power-on reset, active low; clears the cause flag |
| rst_n | input | 1 | Block reset, active low; clears everything except the cause flag |
| tick_i | input | 1 | 1 MHz count enable |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 2 | Register address (0 period, 1 control, 2 config, 3 count) |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Register read data for `reg_addr_i` |
| irq_o | output | 1 | Pending timer interrupt |
| sys_rst_o | output | 1 | System reset request pulse |

## Verification
Two pairs of actions can land in the same clock edge. A software acknowledge can coincide with a second expiry, and a keepalive period write can coincide with the expiring tick. The bench provokes each pair by driving the write and the tick in the same cycle, after first ticking the count down to 1. It judges the acknowledge case by `irq_o` staying high with no reset pulse, followed by a real reset on the next unacknowledged expiry. It judges the keepalive case by `irq_o` staying low and the count reading back as the freshly written value.

// File: rtl/wdt2_pkg.sv
package wdt2_pkg;
  localparam int DATA_W = 32;
  localparam int ADDR_W = 2;

  typedef enum logic [ADDR_W-1:0] {
    A_PERIOD = 2'd0,
    A_CTRL   = 2'd1,
    A_CFG    = 2'd2,
    A_COUNT  = 2'd3
  } wdt2_addr_e;

  localparam int B_RUN   = 31;
  localparam int B_PER   = 30;
  localparam int B_ACK   = 30;
  localparam int B_EN    = 5;
  localparam int B_SEL   = 4;
  localparam int B_RSTEN = 2;
  localparam int B_CAUSE = 12;
endpackage

// File: rtl/wdt2_timer.sv
module wdt2_timer #(
  parameter int CNT_W = 30
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick_i,
  input  logic             load_i,
  input  logic [CNT_W-1:0] load_val_i,
  input  logic             load_run_i,
  input  logic             load_per_i,
  output logic             expire_o,
  output logic [CNT_W-1:0] cnt_o,
  output logic [CNT_W-1:0] reload_o,
  output logic             run_o,
  output logic             per_o
);
  logic [CNT_W-1:0] cnt_q, reload_q;
  logic             run_q, per_q;
  logic             last_tick;

  assign last_tick = cnt_q <= CNT_W'(1);
  assign expire_o  = run_q & tick_i & ~load_i & last_tick;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q    <= '0;
      reload_q <= '0;
      run_q    <= 1'b0;
      per_q    <= 1'b0;
    end else if (load_i) begin
      cnt_q    <= load_val_i;
      reload_q <= load_val_i;
      run_q    <= load_run_i;
      per_q    <= load_per_i;
    end else if (run_q && tick_i) begin
      if (last_tick) begin
        if (per_q) begin
          cnt_q <= reload_q;
        end else begin
          cnt_q <= '0;
          run_q <= 1'b0;
        end
      end else begin
        cnt_q <= cnt_q - CNT_W'(1);
      end
    end
  end

  assign cnt_o    = cnt_q;
  assign reload_o = reload_q;
  assign run_o    = run_q;
  assign per_o    = per_q;
endmodule

// File: rtl/wdt2_strike.sv
module wdt2_strike #(
  parameter int RST_LEN = 4
) (
  input  logic clk,
  input  logic por_n,
  input  logic rst_n,
  input  logic expire_i,
  input  logic ack_i,
  input  logic arm_i,
  input  logic cause_clr_i,
  output logic pending_o,
  output logic sys_rst_o,
  output logic cause_o
);
  localparam int PW = $clog2(RST_LEN + 1);

  logic          pending_q, cause_q, fire;
  logic [PW-1:0] pulse_q;

  assign fire = expire_i & pending_q & ~ack_i & arm_i & (pulse_q == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pending_q <= 1'b0;
    end else if (expire_i) begin
      pending_q <= 1'b1;
    end else if (ack_i) begin
      pending_q <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pulse_q <= '0;
    end else if (fire) begin
      pulse_q <= PW'(RST_LEN);
    end else if (pulse_q != '0) begin
      pulse_q <= pulse_q - PW'(1);
    end
  end

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) begin
      cause_q <= 1'b0;
    end else if (fire) begin
      cause_q <= 1'b1;
    end else if (cause_clr_i) begin
      cause_q <= 1'b0;
    end
  end

  assign pending_o = pending_q;
  assign sys_rst_o = pulse_q != '0;
  assign cause_o   = cause_q;
endmodule

// File: rtl/wdt2_regfile.sv
module wdt2_regfile
  import wdt2_pkg::*;
#(
  parameter int CNT_W = 30
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic [CNT_W-1:0]  cnt_i,
  input  logic [CNT_W-1:0]  reload_i,
  input  logic              run_i,
  input  logic              per_i,
  input  logic              pending_i,
  input  logic              cause_i,
  output logic              period_wr_o,
  output logic              ack_o,
  output logic              cause_clr_o,
  output logic              arm_o,
  output logic [DATA_W-1:0] rdata_o
);
  logic en_q, sel_q, rsten_q;
  logic cfg_wr;

  assign period_wr_o = we_i && (addr_i == A_PERIOD);
  assign ack_o       = we_i && (addr_i == A_CTRL) && wdata_i[B_ACK];
  assign cfg_wr      = we_i && (addr_i == A_CFG);
  assign cause_clr_o = cfg_wr && wdata_i[B_CAUSE];
  assign arm_o       = en_q & ~sel_q & rsten_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q    <= 1'b0;
      sel_q   <= 1'b0;
      rsten_q <= 1'b0;
    end else if (cfg_wr) begin
      en_q    <= wdata_i[B_EN];
      sel_q   <= wdata_i[B_SEL];
      rsten_q <= wdata_i[B_RSTEN];
    end
  end

  always_comb begin
    rdata_o = '0;
    unique case (addr_i)
      A_PERIOD: begin
        rdata_o[CNT_W-1:0] = reload_i;
        rdata_o[B_RUN]     = run_i;
        rdata_o[B_PER]     = per_i;
      end
      A_CTRL:  rdata_o[B_ACK] = pending_i;
      A_CFG: begin
        rdata_o[B_EN]    = en_q;
        rdata_o[B_SEL]   = sel_q;
        rdata_o[B_RSTEN] = rsten_q;
        rdata_o[B_CAUSE] = cause_i;
      end
      default: rdata_o[CNT_W-1:0] = cnt_i;
    endcase
  end
endmodule

// File: rtl/wdt_two_strike.sv
module wdt_two_strike
  import wdt2_pkg::*;
#(
  parameter int CNT_W   = 30,
  parameter int RST_LEN = 4
) (
  input  logic              clk,
  input  logic              por_n,
  input  logic              rst_n,
  input  logic              tick_i,
  input  logic              reg_we_i,
  input  logic [ADDR_W-1:0] reg_addr_i,
  input  logic [DATA_W-1:0] reg_wdata_i,
  output logic [DATA_W-1:0] reg_rdata_o,
  output logic              irq_o,
  output logic              sys_rst_o
);
  logic             period_wr, ack_w, cause_clr_w, arm_w;
  logic             expire_w, run_w, per_w, pending_w, cause_w;
  logic [CNT_W-1:0] cnt_w, reload_w;

  wdt2_regfile #(.CNT_W(CNT_W)) u_regs (
    .clk(clk), .rst_n(rst_n),
    .we_i(reg_we_i), .addr_i(reg_addr_i), .wdata_i(reg_wdata_i),
    .cnt_i(cnt_w), .reload_i(reload_w), .run_i(run_w), .per_i(per_w),
    .pending_i(pending_w), .cause_i(cause_w),
    .period_wr_o(period_wr), .ack_o(ack_w), .cause_clr_o(cause_clr_w),
    .arm_o(arm_w), .rdata_o(reg_rdata_o)
  );

  wdt2_timer #(.CNT_W(CNT_W)) u_timer (
    .clk(clk), .rst_n(rst_n), .tick_i(tick_i),
    .load_i(period_wr), .load_val_i(reg_wdata_i[CNT_W-1:0]),
    .load_run_i(reg_wdata_i[B_RUN]), .load_per_i(reg_wdata_i[B_PER]),
    .expire_o(expire_w), .cnt_o(cnt_w), .reload_o(reload_w),
    .run_o(run_w), .per_o(per_w)
  );

  wdt2_strike #(.RST_LEN(RST_LEN)) u_strike (
    .clk(clk), .por_n(por_n), .rst_n(rst_n),
    .expire_i(expire_w), .ack_i(ack_w), .arm_i(arm_w),
    .cause_clr_i(cause_clr_w),
    .pending_o(pending_w), .sys_rst_o(sys_rst_o), .cause_o(cause_w)
  );

  assign irq_o = pending_w;
endmodule

// File: rtl/wdt2_checker.sv
module wdt2_checker #(
  parameter int CNT_W = 30
) (
  input logic             clk,
  input logic             rst_n,
  input logic             tick_i,
  input logic             reg_we_i,
  input logic [1:0]       reg_addr_i,
  input logic [31:0]      reg_wdata_i,
  input logic             irq_o,
  input logic             sys_rst_o,
  input logic [CNT_W-1:0] cnt,
  input logic             cause
);
  AST_RST_NEEDS_PENDING: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sys_rst_o) |-> $past(irq_o)) else $error("second strike without pending"); // R5

  AST_RST_SETS_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sys_rst_o) |-> cause) else $error("cause flag not set"); // R9

  AST_IRQ_FALL_BY_ACK: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(irq_o) |-> $past(reg_we_i && reg_addr_i == 2'd1 && reg_wdata_i[30]))
    else $error("interrupt dropped without acknowledge"); // R4

  AST_COUNT_HOLDS_NO_TICK: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick_i && !reg_we_i) |=> $stable(cnt)) else $error("count moved without tick"); // R2

  AST_PULSE_MIN_TWO: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sys_rst_o) |=> sys_rst_o) else $error("reset pulse too short"); // R5
endmodule

bind wdt_two_strike wdt2_checker #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .tick_i(tick_i), .reg_we_i(reg_we_i),
  .reg_addr_i(reg_addr_i), .reg_wdata_i(reg_wdata_i), .irq_o(irq_o),
  .sys_rst_o(sys_rst_o), .cnt(cnt_w), .cause(cause_w)
);

// File: tb/wdt_two_strike_tb.sv
module wdt_two_strike_tb;
  localparam int RST_LEN = 4;
  localparam logic [31:0] PER = 32'hC000_0000;
  localparam logic [31:0] ONE = 32'h8000_0000;
  localparam logic [31:0] ACK = 32'h4000_0000;

  logic        clk = 1'b0, por_n = 1'b0, rst_n = 1'b0, tick = 1'b0, we = 1'b0;
  logic [1:0]  addr = '0;
  logic [31:0] wdata = '0, rdata;
  logic        irq, srst;
  int          errs = 0, checks = 0;
  bit          done = 0;

  always #5 clk = ~clk;

  wdt_two_strike #(.RST_LEN(RST_LEN)) u_dut (
    .clk(clk), .por_n(por_n), .rst_n(rst_n), .tick_i(tick),
    .reg_we_i(we), .reg_addr_i(addr), .reg_wdata_i(wdata),
    .reg_rdata_o(rdata), .irq_o(irq), .sys_rst_o(srst)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk); we = 1; addr = a; wdata = d;
    @(negedge clk); we = 0;
  endtask

  task automatic wr_tick(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk); we = 1; addr = a; wdata = d; tick = 1;
    @(negedge clk); we = 0; tick = 0;
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); tick = 1;
      @(negedge clk); tick = 0;
    end
  endtask

  task automatic rd(input logic [1:0] a, output logic [31:0] d);
    addr = a; #1; d = rdata;
  endtask

  task automatic pulse_len(output int n);
    n = 0;
    while (srst && n < 100) begin n++; @(negedge clk); end
  endtask

  initial begin
    logic [31:0] d;
    int n;
    repeat (3) @(negedge clk);
    por_n = 1; rst_n = 1;
    chk("R1 irq", {31'd0, irq}, 0);
    chk("R1 sys_rst", {31'd0, srst}, 0);
    for (int a = 0; a < 4; a++) begin rd(a[1:0], d); chk("R1 reg", d, 0); end

    // sweep over periods in periodic mode
    wr(2, 32'h24);
    for (int p = 1; p <= 5; p++) begin
      wr(0, PER | p);
      rd(3, d); chk("R11 count", d, p);
      if (p > 1) begin ticks(p - 1); chk("R2 early", {31'd0, irq}, 0); end
      ticks(1);
      chk("R2 expiry", {31'd0, irq}, 1);
      rd(1, d); chk("R4 pending bit", d, ACK);
      rd(3, d); chk("R3 reload", d, p);
      wr(1, ACK);
      chk("R4 ack clears", {31'd0, irq}, 0);
      ticks(p);
      chk("R4 second irq", {31'd0, irq}, 1);
      chk("R5 no reset on first", {31'd0, srst}, 0);
      ticks(p);
      chk("R5 reset rises", {31'd0, srst}, 1);
      pulse_len(n);
      chk("R5 pulse length", n, RST_LEN);
      rd(2, d); chk("R9 cause set", d, 32'h1024);
      @(negedge clk); rst_n = 0; @(negedge clk); rst_n = 1;
      chk("R1 irq after rst", {31'd0, irq}, 0);
      rd(2, d); chk("R9 cause survives rst_n", d, 32'h1000);
      wr(2, 32'h1024);
      rd(2, d); chk("R9 cause cleared", d, 32'h24);
    end

    // tick gating
    wr(0, PER | 10);
    repeat (5) @(negedge clk);
    rd(3, d); chk("R2 no tick hold", d, 10);
    ticks(3);
    rd(3, d); chk("R2 three ticks", d, 7);

    // one-shot
    wr(0, ONE | 3);
    ticks(3);
    chk("R3 one-shot expiry", {31'd0, irq}, 1);
    ticks(5);
    rd(3, d); chk("R3 one-shot stays zero", d, 0);
    rd(0, d); chk("R3 run bit cleared", d, 3);
    chk("R3 no second strike", {31'd0, srst}, 0);
    wr(1, ACK);
    ticks(3);
    chk("R3 stopped", {31'd0, irq}, 0);

    // keepalive
    wr(0, PER | 4);
    ticks(3);
    wr(0, PER | 4);
    ticks(3);
    chk("R7 keepalive restarts", {31'd0, irq}, 0);
    ticks(1);
    chk("R7 expiry after restart", {31'd0, irq}, 1);
    wr(1, ACK);
    ticks(3);
    wr_tick(0, PER | 4);
    chk("R7 write beats tick", {31'd0, irq}, 0);
    rd(3, d); chk("R7 fresh count", d, 4);

    // ack colliding with expiry
    ticks(4);
    chk("R8 pending", {31'd0, irq}, 1);
    ticks(3);
    wr_tick(1, ACK);
    chk("R8 irq stays", {31'd0, irq}, 1);
    chk("R8 no reset", {31'd0, srst}, 0);
    ticks(4);
    chk("R8 later reset", {31'd0, srst}, 1);
    pulse_len(n);
    wr(1, ACK);
    wr(2, 32'h1024);

    // not armed
    wr(2, 32'h34);
    wr(0, PER | 2);
    ticks(4);
    chk("R6 irq kept sel", {31'd0, irq}, 1);
    chk("R6 no reset sel", {31'd0, srst}, 0);
    wr(2, 32'h20);
    wr(1, ACK);
    ticks(4);
    chk("R6 no reset rsten off", {31'd0, srst}, 0);
    rd(2, d); chk("R6 no cause", d, 32'h20);

    // stop
    wr(2, 0); wr(0, 0); wr(1, ACK);
    ticks(20);
    chk("R10 irq", {31'd0, irq}, 0);
    chk("R10 reset", {31'd0, srst}, 0);
    rd(3, d); chk("R10 count", d, 0);

    done = 1;
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; errs++;
      $display("FAIL watchdog: actual=hung expected=done");
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
    end
  end
endmodule